// File: doc/BRIEF.md
# Debounced General-Purpose Input Port with Change Flags

This block is a seven-bit general-purpose input port. Every pin passes through a two-flop synchroniser. The host can read the synchronised pin levels at any time. The four lowest pins also have debounced change-of-state detectors.

A free-running divider makes a slow sampling tick from the system clock. The default divisor of 96 turns a 3.6864 MHz clock into a 38.4 kHz tick. A detector accepts a new level only when two successive ticks both see it. Each accepted change sets a sticky flag in the change register. Reading that register clears the flags. While any flag is set and the host has enabled the change interrupt, the block raises an interrupt request.

The surrounding bus logic decodes addresses and drives the read strobe for the change register. The read data outputs are always valid, so that logic only has to select between them.

Top module: `gpin_cos_port`

## Requirements
- R1: `pins_rdata_o` carries the synchronised levels of all seven pins in bits 6..0, with a high pin reading as 1. Bit 7 always reads as 1.
- R2: Only pins 0 to 3 have detectors. A change on pins 4 to 6 sets no flag and raises no interrupt.
- R3: The sampling tick occurs once every `TICK_DIV` clocks. A pin level held for fewer than `TICK_DIV` clocks is never accepted.
- R4: A new level held for at least 2·`TICK_DIV`+3 clocks is always accepted. This holds for low-to-high and for high-to-low changes.
- R5: An accepted change sets its flag. The flag stays set until a clearing read of the change register (`chg_rd_i` high for one clock).
- R6: `chg_rdata_o` holds the four change flags in bits 7..4 (bit 4+i for pin i). It holds the debounced levels of pins 3..0 in bits 3..0.
- R7: A change accepted in the same clock as a clearing read leaves its flag set.
- R8: `irq_o` is high exactly when `irq_en_i` is high and at least one change flag is set.
- R9: After reset all flags are clear. The debounced levels are loaded from the first tick sample, and that load sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 7 | Asynchronous input pins |
| chg_rd_i | input | 1 | Clearing read strobe for the change register |
| irq_en_i | input | 1 | Enables the change interrupt |
| pins_rdata_o | output | 8 | Pin read data: bit 7 is always 1, bits 6..0 are the synchronised pins |
| chg_rdata_o | output | 8 | Change register: flags in bits 7..4, debounced levels in bits 3..0 |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with `TICK_DIV` = 4 and keeps the default widths of seven pins and four detectors. This divisor brings the glitch-rejection and acceptance windows down to a few clocks. A three-clock pulse is therefore always rejected, and an eleven-clock pulse is always accepted. The short windows also let the bench hold the read strobe across an acceptance to exercise the set-over-clear priority. They make reset re-priming with the pins held high observable within tens of cycles.

// File: rtl/gpin_pkg.sv
// gpin_pkg: types shared by the input-port change detector.
// Assumes nothing beyond IEEE 1800-2017 packages.
package gpin_pkg;

    // Detector states. UNPRIMED waits for the first tick sample after reset.
    // STABLE means the debounced level matches the last sample.
    // PENDING means one tick has already seen a differing level.
    typedef enum logic [1:0] {
        CS_UNPRIMED = 2'd0,
        CS_STABLE   = 2'd1,
        CS_PENDING  = 2'd2
    } cos_state_e;

endpackage

// File: rtl/gpin_tick_div.sv
// gpin_tick_div: free-running divider.
// Asserts tick_o for one clock out of every DIV clocks.
// Assumes DIV >= 1. The first tick comes DIV clocks after reset is released.
module gpin_tick_div #(
    parameter int unsigned DIV = 96
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count from 0 to DIV-1, then wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (DIV > 1) begin : g_spacing_chk
            // R3
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/gpin_sync.sv
// gpin_sync: two-flop synchroniser for a bus of independent asynchronous bits.
// Assumes the bits are unrelated, so no bus coherence is needed. Reset value is 0.
module gpin_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two register stages for metastability settling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/gpin_cos_det.sv
// gpin_cos_det: debounced change-of-state detector for one synchronised input.
// On a tick it compares the sample with the debounced level. It accepts a new
// level after two successive ticks see it, and it raises a sticky flag on
// acceptance. clr_i clears the flag, but an acceptance in the same clock wins.
// Assumes tick_i is a one-clock pulse and smp_i is already synchronised.
module gpin_cos_det
    import gpin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic smp_i,
    input  logic clr_i,
    output logic lvl_o,
    output logic delta_o
);
    cos_state_e state_q;
    logic       lvl_q;
    logic       delta_q;
    logic       accept;

    // The second successive tick that sees a differing level confirms the change.
    assign accept = tick_i && (state_q == CS_PENDING) && (smp_i != lvl_q);

    // Debounce state machine, advanced on ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_UNPRIMED;
            lvl_q   <= 1'b0;
        end else if (tick_i) begin
            unique case (state_q)
                CS_UNPRIMED: begin
                    lvl_q   <= smp_i;
                    state_q <= CS_STABLE;
                end
                CS_STABLE: begin
                    if (smp_i != lvl_q)
                        state_q <= CS_PENDING;
                end
                CS_PENDING: begin
                    if (smp_i != lvl_q)
                        lvl_q <= smp_i;
                    state_q <= CS_STABLE;
                end
                default: state_q <= CS_UNPRIMED;
            endcase
        end
    end

    // Sticky flag: set on acceptance, cleared by a read, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            delta_q <= 1'b0;
        else
            delta_q <= accept | (delta_q & ~clr_i);
    end

    assign lvl_o   = lvl_q;
    assign delta_o = delta_q;

    // R3
    lvl_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> $past(tick_i));

    // R3
    flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q) |-> $past(tick_i));

    // R5
    level_change_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) != CS_UNPRIMED) && (lvl_q != $past(lvl_q))) |-> delta_q);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(delta_q) && !$past(clr_i)) |-> delta_q);

    // R9
    prime_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == CS_UNPRIMED) && !$past(delta_q)) |-> !delta_q);
endmodule

// File: rtl/gpin_cos_port.sv
// gpin_cos_port: seven-bit input port with debounced change flags on the low pins.
// Pins are synchronised and then sampled on a divided tick. N_COS detectors
// feed a change register that a read clears. The interrupt request is the
// enabled OR of the change flags.
// Assumes TICK_DIV >= 3, so that the first tick sees settled synchroniser
// outputs, and N_COS <= N_PINS.
module gpin_cos_port #(
    parameter int unsigned N_PINS   = 7,
    parameter int unsigned N_COS    = 4,
    parameter int unsigned TICK_DIV = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              chg_rd_i,
    input  logic              irq_en_i,
    output logic [N_PINS:0]   pins_rdata_o,
    output logic [2*N_COS-1:0] chg_rdata_o,
    output logic              irq_o
);
    logic              tick;
    logic [N_PINS-1:0] pin_s;
    logic [N_COS-1:0]  lvl;
    logic [N_COS-1:0]  delta;

    gpin_tick_div #(.DIV(TICK_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    gpin_sync #(.W(N_PINS)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_s)
    );

    // One detector per change-capable pin.
    generate
        for (genvar gi = 0; gi < N_COS; gi++) begin : g_det
            gpin_cos_det i_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_i  (tick),
                .smp_i   (pin_s[gi]),
                .clr_i   (chg_rd_i),
                .lvl_o   (lvl[gi]),
                .delta_o (delta[gi])
            );
        end
    endgenerate

    // Read paths and interrupt request.
    assign pins_rdata_o = {1'b1, pin_s};
    assign chg_rdata_o  = {delta, lvl};
    assign irq_o        = irq_en_i & (|delta);

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);

    // R1
    top_bit_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pins_rdata_o[N_PINS]);
endmodule

// File: tb/test_gpin_cos_port.sv
module test_gpin_cos_port;
    localparam int unsigned DIV  = 4;
    localparam int unsigned HOLD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pin_i = '0;
    logic       chg_rd_i = 1'b0;
    logic       irq_en_i = 1'b1;
    logic [7:0] pins_rdata_o;
    logic [7:0] chg_rdata_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    gpin_cos_port #(.N_PINS(7), .N_COS(4), .TICK_DIV(DIV)) i_gpin_cos_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin_i),
        .chg_rd_i     (chg_rd_i),
        .irq_en_i     (irq_en_i),
        .pins_rdata_o (pins_rdata_o),
        .chg_rdata_o  (chg_rdata_o),
        .irq_o        (irq_o)
    );

    // Each vector is {pins, expected change register after a HOLD-clock settle}.
    // Expected flags are the old-to-new XOR of pins 3..0, and the levels are the new pins 3..0.
    localparam logic [14:0] VEC [8] = '{
        {7'h01, 8'h11}, {7'h0F, 8'hEF}, {7'h70, 8'hF0}, {7'h7A, 8'hAA},
        {7'h40, 8'hA0}, {7'h45, 8'h55}, {7'h35, 8'h05}, {7'h00, 8'h50}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_read();
        chg_rd_i = 1'b1;
        cyc(1);
        chg_rd_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic seen;
        cyc(3);
        rst_n = 1'b1;
        cyc(HOLD);
        // Reset state: R9 (no flags), R1 (bit 7 set, pins low), R8 (no interrupt).
        chk("R9 reset change reg", chg_rdata_o, 8'h00);
        chk("R1 reset pin read", pins_rdata_o, 8'h80);
        chk("R8 reset irq", {7'b0, irq_o}, 8'h00);

        // Table walk: covers R1, R2, R4, R5, R6 and R8.
        for (int k = 0; k < 8; k++) begin
            pin_i = VEC[k][14:8];
            cyc(HOLD);
            chk("R1 pin read", pins_rdata_o, {1'b1, VEC[k][14:8]});
            chk("R6 R4 R2 change reg", chg_rdata_o, VEC[k][7:0]);
            chk("R8 irq", {7'b0, irq_o}, {7'b0, |VEC[k][7:4]});
            clr_read();
            chk("R5 cleared by read", chg_rdata_o, {4'h0, VEC[k][11:8]});
        end

        // R3: a three-clock glitch is rejected.
        pin_i = 7'h01;
        cyc(3);
        pin_i = 7'h00;
        cyc(HOLD);
        chk("R3 short glitch ignored", chg_rdata_o, 8'h00);

        // R4: an eleven-clock pulse is accepted, and so is the return to low.
        pin_i = 7'h02;
        cyc(2 * DIV + 3);
        pin_i = 7'h00;
        cyc(HOLD);
        chk("R4 long pulse flagged", chg_rdata_o, 8'h20);
        clr_read();

        // R5: the flag survives a long wait with no read, and a second read shows it clear.
        pin_i = 7'h04;
        cyc(HOLD);
        chk("R5 flag set", chg_rdata_o, 8'h44);
        cyc(3 * HOLD);
        chk("R5 flag sticky", chg_rdata_o, 8'h44);
        clr_read();
        clr_read();
        chk("R5 second read clear", chg_rdata_o, 8'h04);

        // R8: the enable gates the request.
        pin_i = 7'h00;
        cyc(HOLD);
        irq_en_i = 1'b0;
        cyc(1);
        chk("R8 irq masked", {7'b0, irq_o}, 8'h00);
        irq_en_i = 1'b1;
        cyc(1);
        chk("R8 irq enabled", {7'b0, irq_o}, 8'h01);
        clr_read();

        // R7: with the read strobe held, an acceptance must still show up for one clock.
        chg_rd_i = 1'b1;
        pin_i = 7'h08;
        seen = 1'b0;
        for (int k = 0; k < 24; k++) begin
            cyc(1);
            if (chg_rdata_o[7]) seen = 1'b1;
        end
        chg_rd_i = 1'b0;
        chk("R7 set wins over clear", {7'b0, seen}, 8'h01);
        cyc(1);
        chk("R7 level after", chg_rdata_o, 8'h08);

        // R9: reset clears a pending flag, and re-priming from high pins sets no flag.
        pin_i = 7'h09;
        cyc(HOLD);
        pin_i = 7'h0F;
        rst_n = 1'b0;
        cyc(3);
        chk("R9 flags cleared in reset", chg_rdata_o, 8'h00);
        rst_n = 1'b1;
        cyc(HOLD);
        chk("R9 primed from pins", chg_rdata_o, 8'h0F);
        chk("R9 no irq after priming", {7'b0, irq_o}, 8'h00);

        finish_run();
    end
endmodule